// File: doc/BRIEF.md
# Beamforming Channel Delay Array

This block times a group of beamformer channels in both directions. On transmit, each channel keeps its own firing delay. A single shared start strobe launches every channel's countdown at the same moment. Each channel raises its fire output once its own delay has run out. Programming each channel with the right delay makes the emissions from all channels reach one focal point together.

On receive, each channel feeds its echo samples into a three-stage delay line. The channel picks one of four taps, giving a delay of zero to three samples, so that echoes from the focal point line up across channels. It then scales the chosen sample by its own weight. A balanced adder tree adds the weighted samples of all channels into one registered sum.

A single write port programs all channels. A channel index selects the target channel, and one write strobe stores that channel's fire delay, tap choice and weight in the same cycle.

Top module: `bf_chan_delay_array`

## Requirements
- R1: After reset, fire is all zero, sum_out is zero and sum_vld is low. Every channel then holds a fire delay of 0, tap 0 and weight 1.
- R2: When cfg_we is high at a clock edge, the channel numbered cfg_ch stores cfg_dly, cfg_tap and cfg_wt. All other channels keep their settings.
- R3: Suppose start_tx is high at clock edge k and channel i holds fire delay d. Then fire[i] is high for exactly one cycle: the cycle that follows edge k+d. A delay of 0 fires in the cycle right after the start edge.
- R4: If start_tx arrives while a channel is still counting down, that channel restarts from its stored delay. It does not fire for the countdown that was cut off.
- R5: After a channel fires, it stays quiet until the next start_tx.
- R6: Bits [i*DW +: DW] of echo_in hold channel i's sample. The 2-bit tap value t picks the sample that was presented t strobes before the current one, and t=0 picks the current sample. Before enough samples have been pushed, the missing history counts as zero.
- R7: The selected sample and the channel weight are both treated as unsigned. The channel multiplies the sample by its weight.
- R8: When echo_vld is high at an edge, sum_out takes the sum of all channels' weighted samples from that edge onward, and sum_vld is high for the following cycle. When echo_vld is low, sum_vld is low.
- R9: sum_out is wide enough that every channel at full-scale sample and full-scale weight still gives the exact sum. With the default parameters this is 8*255*15 = 30600.
- R10: The delay lines and sum_out change only on edges where echo_vld is high. A cycle with echo_vld low leaves the tap history unchanged and holds sum_out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one channel's settings |
| cfg_ch | input | AW | Index of the channel to write |
| cfg_dly | input | CW | Fire delay in cycles |
| cfg_tap | input | 2 | Receive tap choice (0..3 samples) |
| cfg_wt | input | WW | Receive weight |
| start_tx | input | 1 | Shared transmit start |
| fire | output | NCH | One-cycle fire pulse per channel |
| echo_in | input | NCH*DW | Echo samples, channel i in bits [i*DW +: DW] |
| echo_vld | input | 1 | Sample strobe |
| sum_out | output | DW+WW+log2(NCH) | Weighted, aligned beam sum |
| sum_vld | output | 1 | sum_out was updated at the last edge |

## Verification
A wrong countdown value or a wrong busy state moves or duplicates a fire pulse. Because each pulse belongs to a known cycle after the start, the error appears within the programmed delay plus one cycle. A delay-line stage that shifts at the wrong time, or that holds the wrong sample, corrupts sum_out one to three strobes later, depending on which taps are in use. For that reason the bench pushes sequences of distinct samples across mixed taps, and it checks the sum after every strobe. A weight-store or tree fault shows on the very next strobe, so the full-scale sums check the width of the sum path as well as its arithmetic.

// File: rtl/bf_chan_delay_array.sv
module bf_chan_delay_array #(
  parameter int NCH = 8,
  parameter int DW  = 8,
  parameter int WW  = 4,
  parameter int CW  = 8,
  localparam int AW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LV = $clog2(NCH),
  localparam int PW = DW + WW,
  localparam int SW = PW + LV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AW-1:0]     cfg_ch,
  input  logic [CW-1:0]     cfg_dly,
  input  logic [1:0]        cfg_tap,
  input  logic [WW-1:0]     cfg_wt,
  input  logic              start_tx,
  output logic [NCH-1:0]    fire,
  input  logic [NCH*DW-1:0] echo_in,
  input  logic              echo_vld,
  output logic [SW-1:0]     sum_out,
  output logic              sum_vld
);

  logic [SW-1:0] node [1:2*NCH-1];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] dly_q, cnt_q;
    logic          busy_q;
    logic [1:0]    tap_q;
    logic [WW-1:0] wt_q;
    logic [DW-1:0] line_q [3];
    logic [DW-1:0] cur, pick;
    logic          sel;

    assign sel = cfg_we && (cfg_ch == AW'(i));
    assign cur = echo_in[i*DW +: DW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly_q <= '0;
        tap_q <= '0;
        wt_q  <= WW'(1);
      end else if (sel) begin
        dly_q <= cfg_dly;
        tap_q <= cfg_tap;
        wt_q  <= cfg_wt;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (start_tx) begin
        busy_q <= 1'b1;
        cnt_q  <= dly_q;
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end

    assign fire[i] = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < 3; k++) line_q[k] <= '0;
      end else if (echo_vld) begin
        line_q[0] <= cur;
        for (int k = 1; k < 3; k++) line_q[k] <= line_q[k-1];
      end
    end

    always_comb begin
      case (tap_q)
        2'd0:    pick = cur;
        2'd1:    pick = line_q[0];
        2'd2:    pick = line_q[1];
        default: pick = line_q[2];
      endcase
    end

    assign node[NCH+i] = SW'(PW'(pick) * PW'(wt_q));
  end

  for (genvar n = 1; n < NCH; n++) begin : g_tree
    assign node[n] = node[2*n] + node[2*n+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_out <= '0;
      sum_vld <= 1'b0;
    end else begin
      sum_vld <= echo_vld;
      if (echo_vld) sum_out <= node[1];
    end
  end

endmodule

// File: rtl/bf_chan_delay_array_chk.sv
module bf_chan_delay_array_chk #(
  parameter int NCH = 8,
  parameter int SW  = 15
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_tx,
  input logic [NCH-1:0] fire,
  input logic           echo_vld,
  input logic [SW-1:0]  sum_out,
  input logic           sum_vld
);

  logic armed_q;
  always_ff @(posedge clk) begin
    if (!rst_n)        armed_q <= 1'b0;
    else if (start_tx) armed_q <= 1'b1;
  end

  AST_SUM_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    echo_vld |=> sum_vld); // R8
  AST_SUM_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_vld |=> !sum_vld); // R8
  AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !echo_vld |=> $stable(sum_out)); // R10
  AST_FIRE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    (fire != '0) |-> armed_q); // R5

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_FIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (fire[i] && !start_tx) |=> !fire[i]); // R3
  end

endmodule

bind bf_chan_delay_array bf_chan_delay_array_chk #(.NCH(NCH), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_tx(start_tx), .fire(fire),
  .echo_vld(echo_vld), .sum_out(sum_out), .sum_vld(sum_vld)
);

// File: tb/bf_chan_delay_array_tb_top.sv
module bf_chan_delay_array_tb_top;
  localparam int NCH = 8, DW = 8, WW = 4, CW = 8;
  localparam int SW = DW + WW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_ch = '0;
  logic [CW-1:0] cfg_dly = '0;
  logic [1:0] cfg_tap = '0;
  logic [WW-1:0] cfg_wt = '0;
  logic start_tx = 1'b0;
  logic [NCH-1:0] fire;
  logic [NCH*DW-1:0] echo_in = '0;
  logic echo_vld = 1'b0;
  logic [SW-1:0] sum_out;
  logic sum_vld;

  int checks = 0, errors = 0;
  int hist [NCH][3];
  int tapv [NCH];
  int wtv  [NCH];
  int dlyv [NCH];
  int smp  [NCH];
  int last_sum = 0;

  always #10 clk = ~clk;

  bf_chan_delay_array #(.NCH(NCH), .DW(DW), .WW(WW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_dly(cfg_dly), .cfg_tap(cfg_tap), .cfg_wt(cfg_wt),
    .start_tx(start_tx), .fire(fire), .echo_in(echo_in),
    .echo_vld(echo_vld), .sum_out(sum_out), .sum_vld(sum_vld)
  );

  task automatic ck(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input int ch, input int d, input int t, input int w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 3'(ch); cfg_dly = CW'(d); cfg_tap = 2'(t); cfg_wt = WW'(w);
    @(negedge clk);
    cfg_we = 1'b0;
    dlyv[ch] = d; tapv[ch] = t; wtv[ch] = w;
  endtask

  task automatic push(input string req);
    int exp = 0;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      int v;
      echo_in[c*DW +: DW] = DW'(smp[c]);
      v = (tapv[c] == 0) ? smp[c] : hist[c][tapv[c]-1];
      exp += v * wtv[c];
    end
    echo_vld = 1'b1;
    @(negedge clk);
    echo_vld = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      hist[c][2] = hist[c][1]; hist[c][1] = hist[c][0]; hist[c][0] = smp[c];
    end
    ck(sum_out == SW'(exp), req, int'(sum_out), exp);
    ck(sum_vld == 1'b1, "R8 sum_vld after strobe", int'(sum_vld), 1);
    last_sum = exp;
  endtask

  task automatic t_reset;
    ck(fire == '0, "R1 fire at reset", int'(fire), 0);
    ck(sum_out == '0, "R1 sum_out at reset", int'(sum_out), 0);
    ck(sum_vld == 1'b0, "R1 sum_vld at reset", int'(sum_vld), 0);
    for (int c = 0; c < NCH; c++) smp[c] = 3 * c + 1;
    push("R1 default tap 0 weight 1");
  endtask

  task automatic t_fire_pattern;
    int ds [NCH] = '{0, 1, 2, 3, 4, 5, 6, 9};
    for (int c = 0; c < NCH; c++) write_cfg(c, ds[c], tapv[c], wtv[c]);
    @(negedge clk); start_tx = 1'b1;
    @(negedge clk); start_tx = 1'b0;
    for (int n = 0; n < 16; n++) begin
      logic [NCH-1:0] exp = '0;
      for (int c = 0; c < NCH; c++) exp[c] = (ds[c] == n);
      ck(fire == exp, (n > 9) ? "R5 quiet after fire" : "R3 fire cycle", int'(fire), int'(exp));
      @(negedge clk);
    end
  endtask

  task automatic t_restart;
    write_cfg(0, 5, tapv[0], wtv[0]);
    @(negedge clk); start_tx = 1'b1;
    @(negedge clk); start_tx = 1'b0;
    for (int n = 0; n < 2; n++) begin
      ck(fire[0] == 1'b0, "R4 before restart", int'(fire[0]), 0);
      @(negedge clk);
    end
    start_tx = 1'b1;
    @(negedge clk); start_tx = 1'b0;
    for (int n = 0; n < 9; n++) begin
      ck(fire[0] == (n == 5), "R4 fire from restart", int'(fire[0]), int'(n == 5));
      @(negedge clk);
    end
  endtask

  task automatic t_cfg_isolation;
    write_cfg(3, 2, tapv[3], wtv[3]);
    @(negedge clk); start_tx = 1'b1;
    @(negedge clk); start_tx = 1'b0;
    for (int n = 0; n < 10; n++) begin
      ck(fire[3] == (n == 2), "R2 written channel delay", int'(fire[3]), int'(n == 2));
      ck(fire[7] == (n == 9), "R2 other channel kept", int'(fire[7]), int'(n == 9));
      @(negedge clk);
    end
  endtask

  task automatic t_taps;
    for (int c = 0; c < NCH; c++) write_cfg(c, dlyv[c], c % 4, c + 1);
    for (int s = 0; s < 6; s++) begin
      for (int c = 0; c < NCH; c++) smp[c] = (s * 37 + c * 11 + 5) % 256;
      push("R6 R7 tap and weight sum");
    end
  endtask

  task automatic t_hold;
    @(negedge clk);
    ck(sum_vld == 1'b0, "R8 sum_vld idle", int'(sum_vld), 0);
    ck(sum_out == SW'(last_sum), "R10 sum held", int'(sum_out), last_sum);
    @(negedge clk);
    ck(sum_out == SW'(last_sum), "R10 sum held again", int'(sum_out), last_sum);
    for (int c = 0; c < NCH; c++) smp[c] = 200 - c;
    push("R10 history unchanged by idle cycles");
  endtask

  task automatic t_full_scale;
    for (int c = 0; c < NCH; c++) write_cfg(c, dlyv[c], 3, 15);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < NCH; c++) smp[c] = 255;
      push("R9 full scale sum");
    end
    ck(sum_out == SW'(30600), "R9 full scale value", int'(sum_out), 30600);
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) begin
      tapv[c] = 0; wtv[c] = 1; dlyv[c] = 0;
      for (int k = 0; k < 3; k++) hist[c][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fire_pattern();
    t_restart();
    t_cfg_isolation();
    t_taps();
    t_hold();
    t_full_scale();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule